// File: doc/BRIEF.md
# Receive Line Idle Timeout Timer

This block watches a serial receiver for silence once traffic has begun. Software or a neighbouring controller programs a timeout value `V`. The receiver datapath feeds the block two inputs: a one-cycle tick for each bit period and a one-cycle pulse for each completed character. After a restart, the timer does nothing until the first character arrives. From then on it counts down, and each new character reloads the count. If `4 * V` bit periods pass with no new character, it raises a sticky timeout flag.

The wait is counted in units of four bit periods. A small prescaler divides the bit tick by four, so the main down-counter holds exactly the programmed value. A value of zero turns detection off. The flag stays set, and the counter stays stopped, until a restart command clears the flag and re-arms the wait for a first character.

Top module: `rx_idle_timer`

## Requirements
- R1: With a timeout value of zero at the moment a character would arm or reload the timer, no counting takes place. A character that arrives while counting, with the value at zero, returns the block to waiting. The flag stays 0.
- R2: With a non-zero value, bit ticks have no effect until the first character after reset or restart.
- R3: While counting, the main count steps down once for every four bit ticks (prescale of four).
- R4: A character pulse while counting reloads the count with the current value and zeroes the prescaler. A character pulse takes priority over a bit tick in the same cycle.
- R5: The flag rises in the cycle after the edge on which the 4*V-th bit tick since the last character is sampled. It is 0 after fewer ticks.
- R6: A restart pulse clears the flag and returns the block to waiting for a first character. A restart wins over a character pulse in the same cycle.
- R7: The flag is sticky. After expiry, character pulses and bit ticks change nothing until a restart.
- R8: A new timeout value written while counting takes effect only at the next load, whether that load comes from a character or from arming after a restart.
- R9: After reset the flag is 0 and the block waits for a first character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timeout_val | input | VAL_W | Programmed timeout in units of four bit periods; 0 disables |
| bit_tick | input | 1 | One-cycle pulse per receive bit period |
| char_rx | input | 1 | One-cycle pulse per received character |
| restart | input | 1 | One-cycle pulse that clears the flag and re-arms the first-character wait |
| timeout_flag | output | 1 | Sticky idle-timeout indication |

## Verification
Assertions check these rules on every cycle:
- restart takes effect, and beats a character pulse in the same cycle;
- the flag stays set until a restart;
- the count never underflows;
- a load captures the programmed value;
- a zero value never arms the timer;
- the prescaler steps once per tick.

Some properties need whole scenarios, so only the bench's sweeps can show them:
- the exact expiry after 4*V ticks, for every value of a 4-bit configuration;
- reload in mid-gap;
- a late value change that waits for the next load;
- silence after expiry.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

   typedef enum logic [1:0] {
      ST_WAIT    = 2'd0,
      ST_COUNT   = 2'd1,
      ST_EXPIRED = 2'd2
   } rxto_state_t;

endpackage

// File: rtl/rxto_prescaler.sv
module rxto_prescaler #(
   parameter int PRESCALE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic tick,
   output logic stride
);

   if (PRESCALE < 1) begin : g_bad_prescale
      $error("rxto_prescaler: PRESCALE must be at least 1");
   end

   if (PRESCALE == 1) begin : g_direct
      assign stride = en & tick;
   end else begin : g_divide
      localparam int PRE_W = $clog2(PRESCALE);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

      logic [PRE_W-1:0] phase_q;

      assign stride = en & tick & (phase_q == PRE_LAST);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            phase_q <= '0;
         end else if (clr) begin
            phase_q <= '0;
         end else if (en && tick) begin
            if (phase_q == PRE_LAST) phase_q <= '0;
            else                     phase_q <= phase_q + 1'b1;
         end
      end

      // R3: a non-final tick advances the phase by exactly one
      a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
         (en && tick && !clr && !stride) |=> (phase_q == $past(phase_q) + 1'b1));

      // R3: the phase never leaves its range
      a_r3_phase_range: assert property (@(posedge clk) disable iff (!rst_n)
         phase_q <= PRE_LAST);
   end

endmodule

// File: rtl/rxto_down_counter.sv
module rxto_down_counter #(
   parameter int VAL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [VAL_W-1:0] load_val,
   input  logic             dec,
   output logic [VAL_W-1:0] cnt,
   output logic             last
);

   if (VAL_W < 1) begin : g_bad_width
      $error("rxto_down_counter: VAL_W must be at least 1");
   end

   localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

   logic [VAL_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (dec) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign cnt  = cnt_q;
   assign last = (cnt_q == ONE);

   // R5: a step is never requested on an empty count
   a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (cnt_q != '0));

   // R4: a load captures the value presented with it
   a_r4_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/rxto_ctrl.sv
module rxto_ctrl
   import rxto_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        val_nz,
   input  logic        char_rx,
   input  logic        restart,
   input  logic        stride,
   input  logic        last,
   output rxto_state_t state,
   output logic        load,
   output logic        dec,
   output logic        pre_clr,
   output logic        pre_en,
   output logic        flag
);

   rxto_state_t state_q, state_d;
   logic        flag_q, flag_d;

   always_comb begin
      state_d = state_q;
      flag_d  = flag_q;
      load    = 1'b0;
      dec     = 1'b0;
      pre_clr = 1'b0;
      if (restart) begin
         state_d = ST_WAIT;
         flag_d  = 1'b0;
         pre_clr = 1'b1;
      end else begin
         unique case (state_q)
            ST_WAIT: begin
               if (char_rx && val_nz) begin
                  state_d = ST_COUNT;
                  load    = 1'b1;
                  pre_clr = 1'b1;
               end
            end
            ST_COUNT: begin
               if (char_rx) begin
                  pre_clr = 1'b1;
                  if (val_nz) load    = 1'b1;
                  else        state_d = ST_WAIT;
               end else if (stride) begin
                  dec = 1'b1;
                  if (last) begin
                     state_d = ST_EXPIRED;
                     flag_d  = 1'b1;
                  end
               end
            end
            ST_EXPIRED: begin
               state_d = ST_EXPIRED;
            end
            default: begin
               state_d = ST_WAIT;
            end
         endcase
      end
   end

   assign pre_en = (state_q == ST_COUNT) && !char_rx && !restart;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_WAIT;
         flag_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         flag_q  <= flag_d;
      end
   end

   assign state = state_q;
   assign flag  = flag_q;

   // R6: restart clears the flag and re-arms the wait, whatever else arrives
   a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!flag_q && state_q == ST_WAIT));

   // R7: the flag holds until a restart
   a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !restart) |=> flag_q);

   // R7: expiry is a dead end until a restart
   a_r7_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_EXPIRED && !restart) |=> (state_q == ST_EXPIRED));

   // R1: a zero value never arms the timer
   a_r1_zero_no_arm: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && !val_nz && !restart) |=> (state_q == ST_WAIT));

   // R2: without a character the wait persists
   a_r2_wait_first: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WAIT && !char_rx) |=> (state_q == ST_WAIT && !flag_q));

   // R5: the flag appears only when leaving the counting state
   a_r5_flag_origin: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q) |-> ($past(state_q) == ST_COUNT && state_q == ST_EXPIRED));

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
   import rxto_pkg::*;
#(
   parameter int VAL_W    = 8,
   parameter int PRESCALE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VAL_W-1:0] timeout_val,
   input  logic             bit_tick,
   input  logic             char_rx,
   input  logic             restart,
   output logic             timeout_flag
);

   if (VAL_W < 1 || VAL_W > 32) begin : g_bad_val_w
      $error("rx_idle_timer: VAL_W must lie in 1..32");
   end

   logic             val_nz;
   logic             load, dec, pre_clr, pre_en, stride, last;
   logic [VAL_W-1:0] cnt;
   rxto_state_t      state;

   assign val_nz = |timeout_val;

   rxto_prescaler #(.PRESCALE(PRESCALE)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (pre_clr),
      .en     (pre_en),
      .tick   (bit_tick),
      .stride (stride)
   );

   rxto_down_counter #(.VAL_W(VAL_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (timeout_val),
      .dec      (dec),
      .cnt      (cnt),
      .last     (last)
   );

   rxto_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .val_nz  (val_nz),
      .char_rx (char_rx),
      .restart (restart),
      .stride  (stride),
      .last    (last),
      .state   (state),
      .load    (load),
      .dec     (dec),
      .pre_clr (pre_clr),
      .pre_en  (pre_en),
      .flag    (timeout_flag)
   );

   // R1/R5: a counting timer always holds a non-zero count
   a_r5_count_live: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_COUNT) |-> (cnt != '0));

endmodule

// File: tb/sim_rx_idle_timer.sv
module sim_rx_idle_timer;

   localparam int VW  = 4;
   localparam int PRE = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [VW-1:0] timeout_val = '0;
   logic          bit_tick = 1'b0;
   logic          char_rx = 1'b0;
   logic          restart = 1'b0;
   logic          timeout_flag;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;

   always #4 clk = ~clk;

   rx_idle_timer #(.VAL_W(VW), .PRESCALE(PRE)) u0 (
      .clk          (clk),
      .rst_n        (rst_n),
      .timeout_val  (timeout_val),
      .bit_tick     (bit_tick),
      .char_rx      (char_rx),
      .restart      (restart),
      .timeout_flag (timeout_flag)
   );

   task automatic check(input logic act, input logic exp, input string req);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: timeout_flag=%0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         bit_tick = 1'b1;
         @(negedge clk);
         bit_tick = 1'b0;
      end
   endtask

   task automatic send_char();
      char_rx = 1'b1;
      @(negedge clk);
      char_rx = 1'b0;
   endtask

   task automatic do_restart();
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check(timeout_flag, 1'b0, "R9 reset flag");
      rst_n = 1'b1;
      @(negedge clk);
      check(timeout_flag, 1'b0, "R9 after reset release");

      // R2: a non-zero value but no character: ticks do nothing
      timeout_val = 4'd2;
      ticks(40);
      check(timeout_flag, 1'b0, "R2 no first character");

      // R1: zero value, character and ticks: never arms
      timeout_val = 4'd0;
      send_char();
      ticks(100);
      check(timeout_flag, 1'b0, "R1 zero disables");

      // R3/R5: sweep every non-zero value
      for (int v = 1; v < (1 << VW); v++) begin
         do_restart();
         timeout_val = VW'(v);
         send_char();
         ticks(4 * v - 1);
         check(timeout_flag, 1'b0, $sformatf("R3 v=%0d before expiry", v));
         ticks(1);
         check(timeout_flag, 1'b1, $sformatf("R5 v=%0d at expiry", v));
         // R7: character and ticks after expiry change nothing
         send_char();
         ticks(4 * v + 3);
         check(timeout_flag, 1'b1, $sformatf("R7 v=%0d sticky", v));
      end

      // R6: restart clears and re-arms the first-character wait
      do_restart();
      check(timeout_flag, 1'b0, "R6 restart clears flag");
      ticks(80);
      check(timeout_flag, 1'b0, "R6 waits for first character");

      // R4: reload on a mid-gap character
      timeout_val = 4'd5;
      send_char();
      ticks(19);
      send_char();
      ticks(19);
      check(timeout_flag, 1'b0, "R4 reload restarts the gap");
      ticks(1);
      check(timeout_flag, 1'b1, "R4 expiry after reload");

      // R4: a character beats a tick in the same cycle, and the prescaler clears
      do_restart();
      timeout_val = 4'd1;
      send_char();
      ticks(2);
      char_rx = 1'b1;
      bit_tick = 1'b1;
      @(negedge clk);
      char_rx = 1'b0;
      bit_tick = 1'b0;
      ticks(3);
      check(timeout_flag, 1'b0, "R4 character wins over tick");
      ticks(1);
      check(timeout_flag, 1'b1, "R4 expiry four ticks after tie");

      // R8: a new value waits for the next load
      do_restart();
      timeout_val = 4'd2;
      send_char();
      timeout_val = 4'd6;
      ticks(7);
      check(timeout_flag, 1'b0, "R8 old value still counting");
      ticks(1);
      check(timeout_flag, 1'b1, "R8 old value expires");
      do_restart();
      send_char();
      ticks(23);
      check(timeout_flag, 1'b0, "R8 new value after restart");
      ticks(1);
      check(timeout_flag, 1'b1, "R8 new value expires");

      // R1: a zero value at reload stops counting, next character re-arms
      do_restart();
      timeout_val = 4'd3;
      send_char();
      ticks(5);
      timeout_val = 4'd0;
      send_char();
      ticks(100);
      check(timeout_flag, 1'b0, "R1 zero at reload stops");
      timeout_val = 4'd2;
      ticks(20);
      check(timeout_flag, 1'b0, "R1 waiting after stop");
      send_char();
      ticks(8);
      check(timeout_flag, 1'b1, "R1 re-armed by character");

      // R6: restart wins over a character in the same cycle
      do_restart();
      timeout_val = 4'd1;
      restart = 1'b1;
      char_rx = 1'b1;
      @(negedge clk);
      restart = 1'b0;
      char_rx = 1'b0;
      ticks(12);
      check(timeout_flag, 1'b0, "R6 restart beats character");

      finish_run();
   end

endmodule